// File: doc/BRIEF.md
# Two-Port Flag and Payload Mailbox

This block passes one-way messages from a sending processor (port A) to a receiving processor (port B) through a register map. The sender loads three 32-bit payload words: a command, an address and a data or length word. It then raises one or more of 32 event flags. The receiver sees the flags as status and reads the payload through read-only mirrors. It signals completion by acknowledging flags, and it can return a 32-bit answer through a reply register that the sender reads.

Flags 0 to 3 each drive a level interrupt line toward the receiver. The remaining flags carry whatever meaning software gives them, for example "command pending". The sender can also withdraw its own flags with a clear register. Both ports use a plain synchronous register bus: word address, write enable, write data, and registered read data. A full link uses two instances, one for each direction.

Port A map (word address): 0 flags (read-only), 1 set (write-one), 2 clear (write-one), 3 command, 4 address, 5 data, 6 reply view (read-only). Port B map: 0 status (read-only), 1 acknowledge (write-one), 2 command mirror, 3 address mirror, 4 data mirror (mirrors read-only), 5 local reply. Address 7 on port A, and addresses 6 and 7 on port B, are unmapped.

Top module: `mbox_link`

## Requirements
- R1: After synchronous reset, all flags are cleared, every payload and reply register is zero, both read data outputs are zero and all interrupt lines are low.
- R2: Words written on port A at address 3 (command), 4 (address) and 5 (data) read back unchanged on port A at the same addresses, and on port B at addresses 2, 3 and 4.
- R3: Writing to port A address 1 sets each flag whose write-data bit is one, and leaves flags with a zero bit unchanged. The flags read at port A address 0 and at port B address 0, with bit n being flag n.
- R4: Writing to port B address 1 clears each flag whose write-data bit is one. Port A then reads those bits as zero, and other flags are unchanged.
- R5: Writing to port A address 2 clears each flag whose write-data bit is one, with no action on port B.
- R6: When a set and an acknowledge hit the same flag in the same cycle, the flag ends cleared. A set of a different flag in that cycle still takes effect.
- R7: Interrupt output bit i (i = 0..3) is high exactly while flag i is set. Flags 4 to 31 never affect the interrupt outputs.
- R8: A word written on port B address 5 is read on port A address 6.
- R9: The set, clear and acknowledge addresses read as zero. Writes to read-only or unmapped addresses change no register.
- R10: Read data shows the register selected by the address one clock after the address is presented. A write is visible to a read presented in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | 3 | Sender word address |
| a_we | input | 1 | Sender write enable |
| a_wdata | input | 32 | Sender write data |
| a_rdata | output | 32 | Sender registered read data |
| b_addr | input | 3 | Receiver word address |
| b_we | input | 1 | Receiver write enable |
| b_wdata | input | 32 | Receiver write data |
| b_rdata | output | 32 | Receiver registered read data |
| irq | output | 4 | Level interrupts to receiver, one per flag 0..3 |

## Verification
The payload path is exercised with distinct, bit-rich words in each register, so that a swapped mirror or a stuck bit shows up. The flag path is exercised with sparse and overlapping masks: repeated sets show whether zero bits are preserved, and partial clears or acknowledges show whether untouched flags survive. A set and an acknowledge issued in the same cycle on overlapping masks separates the clear-wins rule from set-wins. Writes to read-only mirrors and unmapped addresses, followed by readback, expose decode leaks. A read held across an address change confirms the one-cycle latency.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int REG_AW = 3;
  localparam int NREG   = 2 ** REG_AW;

  // Sender side word addresses
  localparam logic [REG_AW-1:0] A_FLAGS = 3'd0;
  localparam logic [REG_AW-1:0] A_SET   = 3'd1;
  localparam logic [REG_AW-1:0] A_CLEAR = 3'd2;
  localparam logic [REG_AW-1:0] A_CMD   = 3'd3;
  localparam logic [REG_AW-1:0] A_ADDR  = 3'd4;
  localparam logic [REG_AW-1:0] A_DATA  = 3'd5;
  localparam logic [REG_AW-1:0] A_REPLY = 3'd6;

  // Receiver side word addresses
  localparam logic [REG_AW-1:0] B_STATUS = 3'd0;
  localparam logic [REG_AW-1:0] B_ACK    = 3'd1;
  localparam logic [REG_AW-1:0] B_CMD    = 3'd2;
  localparam logic [REG_AW-1:0] B_ADDR   = 3'd3;
  localparam logic [REG_AW-1:0] B_DATA   = 3'd4;
  localparam logic [REG_AW-1:0] B_REPLY  = 3'd5;

  // Index of each payload word inside the payload bank
  localparam int PL_CMD  = 0;
  localparam int PL_ADDR = 1;
  localparam int PL_DATA = 2;
  localparam int NPAYLOAD = 3;
endpackage

// File: rtl/mbox_flag_bank.sv
module mbox_flag_bank #(
  parameter int NUM_FLAGS = 32,
  parameter int NUM_IRQ   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] set_vec,
  input  logic [NUM_FLAGS-1:0] clr_vec,
  input  logic [NUM_FLAGS-1:0] ack_vec,
  output logic [NUM_FLAGS-1:0] flag_q,
  output logic [NUM_IRQ-1:0]   irq
);
  // One flop per flag; removal (clear or acknowledge) has priority over set.
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic drop;
    assign drop = clr_vec[i] | ack_vec[i];
    always_ff @(posedge clk) begin
      if (rst)              flag_q[i] <= 1'b0;
      else if (drop)        flag_q[i] <= 1'b0;
      else if (set_vec[i])  flag_q[i] <= 1'b1;
    end
  end

  // Interrupt lines follow the low flags directly from their flops.
  assign irq = flag_q[NUM_IRQ-1:0];
endmodule

// File: rtl/mbox_word_reg.sv
module mbox_word_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= din;
  end
endmodule

// File: rtl/mbox_rd_port.sv
module mbox_rd_port #(
  parameter int DATA_W = 32,
  parameter int AW     = 3,
  localparam int N     = 2 ** AW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            addr,
  input  logic [N-1:0][DATA_W-1:0] words,
  output logic [DATA_W-1:0]        rdata
);
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= words[addr];
  end
endmodule

// File: rtl/mbox_link.sv
module mbox_link
  import mbox_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_FLAGS = 32,
  parameter int NUM_IRQ   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] a_addr,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [REG_AW-1:0] b_addr,
  input  logic              b_we,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic [NUM_IRQ-1:0] irq
);
  // Write-one strobe masks derived from each port
  logic [NUM_FLAGS-1:0] set_vec, clr_vec, ack_vec;
  assign set_vec = (a_we && a_addr == A_SET)   ? a_wdata[NUM_FLAGS-1:0] : '0;
  assign clr_vec = (a_we && a_addr == A_CLEAR) ? a_wdata[NUM_FLAGS-1:0] : '0;
  assign ack_vec = (b_we && b_addr == B_ACK)   ? b_wdata[NUM_FLAGS-1:0] : '0;

  logic [NUM_FLAGS-1:0] flag_q;

  mbox_flag_bank #(
    .NUM_FLAGS(NUM_FLAGS),
    .NUM_IRQ  (NUM_IRQ)
  ) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .ack_vec(ack_vec),
    .flag_q (flag_q),
    .irq    (irq)
  );

  // Payload bank owned by the sender
  localparam logic [REG_AW-1:0] PL_ADDR_MAP [NPAYLOAD] = '{A_CMD, A_ADDR, A_DATA};
  logic [NPAYLOAD-1:0][DATA_W-1:0] pl_q;

  for (genvar p = 0; p < NPAYLOAD; p++) begin : g_payload
    mbox_word_reg #(.DATA_W(DATA_W)) u_reg (
      .clk(clk),
      .rst(rst),
      .wr (a_we && a_addr == PL_ADDR_MAP[p]),
      .din(a_wdata),
      .q  (pl_q[p])
    );
  end

  // Reply register owned by the receiver
  logic [DATA_W-1:0] reply_q;
  mbox_word_reg #(.DATA_W(DATA_W)) u_reply (
    .clk(clk),
    .rst(rst),
    .wr (b_we && b_addr == B_REPLY),
    .din(b_wdata),
    .q  (reply_q)
  );

  // Flag view widened to the bus
  logic [DATA_W-1:0] flag_view;
  always_comb begin
    flag_view = '0;
    flag_view[NUM_FLAGS-1:0] = flag_q;
  end

  // Read maps; write-one and unmapped slots are zero
  logic [NREG-1:0][DATA_W-1:0] a_words, b_words;
  always_comb begin
    a_words          = '0;
    a_words[A_FLAGS] = flag_view;
    a_words[A_CMD]   = pl_q[PL_CMD];
    a_words[A_ADDR]  = pl_q[PL_ADDR];
    a_words[A_DATA]  = pl_q[PL_DATA];
    a_words[A_REPLY] = reply_q;
  end
  always_comb begin
    b_words           = '0;
    b_words[B_STATUS] = flag_view;
    b_words[B_CMD]    = pl_q[PL_CMD];
    b_words[B_ADDR]   = pl_q[PL_ADDR];
    b_words[B_DATA]   = pl_q[PL_DATA];
    b_words[B_REPLY]  = reply_q;
  end

  mbox_rd_port #(.DATA_W(DATA_W), .AW(REG_AW)) u_rd_a (
    .clk  (clk),
    .rst  (rst),
    .addr (a_addr),
    .words(a_words),
    .rdata(a_rdata)
  );

  mbox_rd_port #(.DATA_W(DATA_W), .AW(REG_AW)) u_rd_b (
    .clk  (clk),
    .rst  (rst),
    .addr (b_addr),
    .words(b_words),
    .rdata(b_rdata)
  );
endmodule

// File: rtl/mbox_link_chk.sv
module mbox_link_chk
  import mbox_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_FLAGS = 32,
  parameter int NUM_IRQ   = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [REG_AW-1:0]    a_addr,
  input logic                 a_we,
  input logic [DATA_W-1:0]    a_wdata,
  input logic [DATA_W-1:0]    a_rdata,
  input logic [REG_AW-1:0]    b_addr,
  input logic                 b_we,
  input logic [DATA_W-1:0]    b_wdata,
  input logic [DATA_W-1:0]    b_rdata,
  input logic [NUM_IRQ-1:0]   irq,
  input logic [NUM_FLAGS-1:0] flags
);
  // R1: the cycle after reset, outputs are quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (irq == '0 && a_rdata == '0 && b_rdata == '0 && flags == '0));

  // R3: set bits not acknowledged in the same cycle appear
  p_set_r3: assert property (@(posedge clk) disable iff (rst)
    (a_we && a_addr == A_SET && !(b_we && b_addr == B_ACK)) |=>
      ((flags & $past(a_wdata[NUM_FLAGS-1:0])) == $past(a_wdata[NUM_FLAGS-1:0])));

  // R3: without any flag write, flags hold
  p_flags_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!(a_we && (a_addr == A_SET || a_addr == A_CLEAR)) && !(b_we && b_addr == B_ACK))
      |=> $stable(flags));

  // R4 / R6: acknowledged bits are low next cycle, even if set at once
  p_ack_r4: assert property (@(posedge clk) disable iff (rst)
    (b_we && b_addr == B_ACK) |=> ((flags & $past(b_wdata[NUM_FLAGS-1:0])) == '0));

  // R5: sender clear drops bits
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (a_we && a_addr == A_CLEAR) |=> ((flags & $past(a_wdata[NUM_FLAGS-1:0])) == '0));

  // R7: a rising interrupt comes only from a set write
  p_irq_source_r7: assert property (@(posedge clk) disable iff (rst)
    ((irq & ~$past(irq)) != '0) |-> $past(a_we && a_addr == A_SET));

  // R8: reply written on B, addressed on A next cycle, lands on A read data
  p_reply_r8: assert property (@(posedge clk) disable iff (rst)
    (b_we && b_addr == B_REPLY) ##1 (a_addr == A_REPLY && !(b_we && b_addr == B_REPLY))
      |=> (a_rdata == $past(b_wdata, 2)));

  // R9: write-one addresses read as zero
  p_wo_zero_a_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(a_addr) == A_SET || $past(a_addr) == A_CLEAR) |-> a_rdata == '0);
  p_wo_zero_b_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(b_addr) == B_ACK) |-> b_rdata == '0);
endmodule

bind mbox_link mbox_link_chk #(
  .DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS), .NUM_IRQ(NUM_IRQ)
) u_chk (
  .clk(clk), .rst(rst),
  .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
  .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata),
  .irq(irq), .flags(flag_q)
);

// File: tb/tb_mbox_link.sv
module tb_mbox_link;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  a_addr = '0, b_addr = '0;
  logic        a_we = 1'b0, b_we = 1'b0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic [3:0]  irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mbox_link dut (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_a(input logic [2:0] ad, input logic [31:0] d);
    @(negedge clk); a_addr = ad; a_wdata = d; a_we = 1'b1;
    @(negedge clk); a_we = 1'b0;
  endtask

  task automatic wr_b(input logic [2:0] ad, input logic [31:0] d);
    @(negedge clk); b_addr = ad; b_wdata = d; b_we = 1'b1;
    @(negedge clk); b_we = 1'b0;
  endtask

  task automatic rd_a(input logic [2:0] ad, output logic [31:0] d);
    @(negedge clk); a_addr = ad; a_we = 1'b0;
    @(negedge clk); d = a_rdata;
  endtask

  task automatic rd_b(input logic [2:0] ad, output logic [31:0] d);
    @(negedge clk); b_addr = ad; b_we = 1'b0;
    @(negedge clk); d = b_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 a_rdata", a_rdata, 32'h0);
    check("R1 b_rdata", b_rdata, 32'h0);
    check("R1 irq", {28'h0, irq}, 32'h0);
    rd_a(3'd0, v); check("R1 flags", v, 32'h0);
    rd_a(3'd3, v); check("R1 cmd", v, 32'h0);
    rd_a(3'd6, v); check("R1 reply", v, 32'h0);
  endtask

  task automatic t_payload;
    logic [31:0] v;
    wr_a(3'd3, 32'h0000_0001);
    wr_a(3'd4, 32'h0000_9400);
    wr_a(3'd5, 32'hA5C3_0080);
    rd_a(3'd3, v); check("R2 A cmd", v, 32'h0000_0001);
    rd_a(3'd5, v); check("R2 A data", v, 32'hA5C3_0080);
    rd_b(3'd2, v); check("R2 B cmd", v, 32'h0000_0001);
    rd_b(3'd3, v); check("R2 B addr", v, 32'h0000_9400);
    rd_b(3'd4, v); check("R2 B data", v, 32'hA5C3_0080);
  endtask

  task automatic t_set_ack_clear;
    logic [31:0] v;
    wr_a(3'd1, 32'h0001_0008);            // flag 16 and flag 3
    check("R7 irq after set", {28'h0, irq}, 32'h8);
    wr_a(3'd1, 32'h8000_0000);            // zero bits keep flags
    rd_a(3'd0, v); check("R3 A flags", v, 32'h8001_0008);
    rd_b(3'd0, v); check("R3 B status", v, 32'h8001_0008);
    check("R7 high flag no irq", {28'h0, irq}, 32'h8);
    wr_b(3'd1, 32'h0001_0000);            // ack flag 16 only
    rd_a(3'd0, v); check("R4 after ack16", v, 32'h8000_0008);
    wr_b(3'd1, 32'h0000_0008);
    check("R7 irq drops", {28'h0, irq}, 32'h0);
    rd_a(3'd0, v); check("R4 after ack3", v, 32'h8000_0000);
    wr_a(3'd1, 32'h0000_0003);
    wr_a(3'd2, 32'h8000_0001);            // sender clear
    rd_b(3'd0, v); check("R5 after clear", v, 32'h0000_0002);
    check("R7 irq bit1", {28'h0, irq}, 32'h2);
    wr_a(3'd2, 32'hFFFF_FFFF);
    rd_a(3'd0, v); check("R5 clear all", v, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    @(negedge clk);
    a_addr = 3'd1; a_wdata = 32'h0000_0005; a_we = 1'b1;
    b_addr = 3'd1; b_wdata = 32'h0000_0001; b_we = 1'b1;
    @(negedge clk); a_we = 1'b0; b_we = 1'b0;
    rd_a(3'd0, v); check("R6 ack wins", v, 32'h0000_0004);
    check("R6 irq", {28'h0, irq}, 32'h4);
    wr_a(3'd2, 32'hFFFF_FFFF);
  endtask

  task automatic t_reply;
    logic [31:0] v;
    wr_b(3'd5, 32'h0000_0210);
    rd_a(3'd6, v); check("R8 reply", v, 32'h0000_0210);
    rd_b(3'd5, v); check("R8 local readback", v, 32'h0000_0210);
  endtask

  task automatic t_ignore;
    logic [31:0] v;
    wr_a(3'd1, 32'h0000_0100);
    rd_a(3'd1, v); check("R9 set reads zero", v, 32'h0);
    rd_a(3'd2, v); check("R9 clear reads zero", v, 32'h0);
    rd_b(3'd1, v); check("R9 ack reads zero", v, 32'h0);
    wr_b(3'd2, 32'hDEAD_BEEF);            // mirror is read-only
    wr_b(3'd6, 32'hDEAD_BEEF);            // unmapped
    wr_a(3'd6, 32'hDEAD_BEEF);            // reply view read-only
    wr_a(3'd0, 32'hFFFF_FFFF);            // flag view read-only
    wr_a(3'd7, 32'hFFFF_FFFF);            // unmapped
    rd_b(3'd2, v); check("R9 mirror kept", v, 32'h0000_0001);
    rd_a(3'd6, v); check("R9 reply kept", v, 32'h0000_0210);
    rd_a(3'd0, v); check("R9 flags kept", v, 32'h0000_0100);
    rd_a(3'd7, v); check("R9 unmapped zero", v, 32'h0);
    wr_a(3'd2, 32'h0000_0100);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    @(negedge clk); a_addr = 3'd4; a_wdata = 32'h1234_5678; a_we = 1'b1;
    @(negedge clk); a_we = 1'b0;          // read of addr 4 in the cycle after write
    @(negedge clk); check("R10 write then read", a_rdata, 32'h1234_5678);
    a_addr = 3'd3;
    #2; check("R10 old data held", a_rdata, 32'h1234_5678);
    @(negedge clk); check("R10 new data", a_rdata, 32'h0000_0001);
    v = 32'h0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_payload();
    t_set_ack_clear();
    t_collide();
    t_reply();
    t_ignore();
    t_latency();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule